// File: doc/BRIEF.md
# Period timer with polarity-selectable compare output

A 16-bit general-purpose timer with a register interface for software. Once its run bit is set, the counter climbs from zero to a programmable period value, then goes back to zero and repeats. A power-of-two input prescaler sets how fast it advances. Each time the counter wraps, the timer sets a sticky period flag and emits a one-cycle period pulse for downstream logic. Software clears the flag by writing a 1 to it.

A compare value drives a single output pin. The value is double-buffered: software writes a buffer, and the live compare value loads from that buffer only on the selected reload condition. The default condition is the counter being zero, so an update lands at a clean period boundary. The output is active while the counter is at or above the live compare value. A polarity field chooses active-low, active-high, forced-low or forced-high. A global output enable parks the pin low when it is clear. A separate compare-enable bit holds the pin at its inactive level.

Software uses one write port and one combinational read port. The register map is as follows:
- address 0 is control: bit 0 run, bit 1 compare enable, bits 4:2 prescale code, bits 6:5 reload condition.
- address 1 is output control: bits 1:0 polarity, bit 2 global enable.
- address 2 is the period.
- address 3 is the compare buffer.
- address 4 is the counter.
- address 5 is status: bit 0 is the period flag, and writing 1 to it clears the flag.

Top module: `gp_period_timer`

## Requirements
- R1: While running with prescale code 000, the counter advances by one on every clock. In the clock after it holds the period value it reads 0, so its sequence is 0, 1, ..., period, 0, ...
- R2: Prescale code k (control bits 4:2) advances the counter once every 2^k clocks, measured from the write that sets the run bit. Code 000 divides by 1.
- R3: On the clock edge at which the counter wraps from the period value to 0, the period flag (status bit 0) is set. On that same edge the period pulse goes high, and it stays high for that one cycle only.
- R4: Writing 1 to status bit 0 clears the period flag, and writing 0 leaves it unchanged. If a clear write falls on the same edge as a wrap, the flag stays set.
- R5: A write to the compare buffer reaches the live compare value according to the reload code in control bits 6:5. Code 00 loads when the counter is 0. Code 01 loads when the counter is 0 or equal to the period. Code 10 loads on every clock. Code 11 behaves like 00.
- R6: With the global enable and compare enable set, the compare condition is counter >= live compare and live compare <= period. Polarity 01 drives 0 while that condition holds and 1 otherwise. Polarity 10 drives the reverse. Polarity 00 always drives 0, and polarity 11 always drives 1.
- R7: When the global enable (output control bit 2) is clear, the compare output is 0 whatever the polarity.
- R8: When compare enable (control bit 1) is clear and the global enable is set, the output sits at its inactive level: 1 for polarity 01 and 0 for polarity 10.
- R9: Clearing the run bit (control bit 0) holds the counter at its value. A write to address 4 loads the counter directly.
- R10: A live compare value of 0 keeps the output active for every count up to and including the period. A live compare value above the period keeps it inactive.
- R11: After reset every register reads 0, the counter is stopped at 0, and the compare output, period flag and period pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cmp_out | output | 1 | Compare output pin |
| period_pulse | output | 1 | One-cycle pulse on each counter wrap |
| period_flag | output | 1 | Sticky period flag, write-1-to-clear |

## Verification
Two functions can fall in the same cycle: the wrap that sets the period flag, and a software write that clears it. The bench polls the counter at each falling edge until it reads the period value. At that same falling edge it drives the write-1-to-clear, so the write and the wrap share the next rising edge. The flag is judged correct only if it is still set and the pulse is high afterwards. A second pairing puts a compare-buffer write against the reload condition. Here the output level is checked while the counter is parked away from zero, then checked again once a counter write to zero (or to the period, for reload code 01) has let the buffered value through.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int ADDR_W = 3;
  localparam int PSC_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUTCTL = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

  // control word bit positions
  localparam int CTL_RUN     = 0;
  localparam int CTL_CMPEN   = 1;
  localparam int CTL_PSC_LSB = 2;
  localparam int CTL_RLD_LSB = CTL_PSC_LSB + PSC_W;

  // output-control word bit positions
  localparam int OC_POL_LSB = 0;
  localparam int OC_GLB     = 2;

  typedef enum logic [1:0] {
    RLD_ZERO     = 2'b00,
    RLD_ZERO_PRD = 2'b01,
    RLD_NOW      = 2'b10,
    RLD_SPARE    = 2'b11
  } reload_e;

  typedef enum logic [1:0] {
    POL_LOW    = 2'b00,
    POL_ACT_LO = 2'b01,
    POL_ACT_HI = 2'b10,
    POL_HIGH   = 2'b11
  } pol_e;

endpackage

// File: rtl/gpt_rst_sync.sv
module gpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 wrap,
  output logic                 run,
  output logic                 cmp_en,
  output logic [PSC_W-1:0]     psc,
  output reload_e              reload,
  output pol_e                 pol,
  output logic                 glb_en,
  output logic [CNT_W-1:0]     period,
  output logic [CNT_W-1:0]     cmp_buf,
  output logic                 flag,
  output logic                 flag_clr,
  output logic                 cnt_wr,
  output logic [CNT_W-1:0]     cnt_wdata
);

  logic             run_q, run_d;
  logic             cmpen_q, cmpen_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  reload_e          rld_q, rld_d;
  pol_e             pol_q, pol_d;
  logic             glb_q, glb_d;
  logic [CNT_W-1:0] prd_q, prd_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic             flag_q, flag_d;

  always_comb begin
    flag_clr  = wr_en && (wr_addr == A_STATUS) && wr_data[0];
    cnt_wr    = wr_en && (wr_addr == A_CNT);
    cnt_wdata = wr_data;
  end

  // next-state
  always_comb begin
    run_d   = run_q;
    cmpen_d = cmpen_q;
    psc_d   = psc_q;
    rld_d   = rld_q;
    pol_d   = pol_q;
    glb_d   = glb_q;
    prd_d   = prd_q;
    buf_d   = buf_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_d   = wr_data[CTL_RUN];
          cmpen_d = wr_data[CTL_CMPEN];
          psc_d   = wr_data[CTL_PSC_LSB +: PSC_W];
          rld_d   = reload_e'(wr_data[CTL_RLD_LSB +: 2]);
        end
        A_OUTCTL: begin
          pol_d = pol_e'(wr_data[OC_POL_LSB +: 2]);
          glb_d = wr_data[OC_GLB];
        end
        A_PERIOD: prd_d = wr_data;
        A_CMP:    buf_d = wr_data;
        default:  ;
      endcase
    end
    // a wrap on the same edge as a clear wins
    if (wrap) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cmpen_q <= 1'b0;
      psc_q   <= '0;
      rld_q   <= RLD_ZERO;
      pol_q   <= POL_LOW;
      glb_q   <= 1'b0;
      prd_q   <= '0;
      buf_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      cmpen_q <= cmpen_d;
      psc_q   <= psc_d;
      rld_q   <= rld_d;
      pol_q   <= pol_d;
      glb_q   <= glb_d;
      prd_q   <= prd_d;
      buf_q   <= buf_d;
      flag_q  <= flag_d;
    end
  end

  assign run     = run_q;
  assign cmp_en  = cmpen_q;
  assign psc     = psc_q;
  assign reload  = rld_q;
  assign pol     = pol_q;
  assign glb_en  = glb_q;
  assign period  = prd_q;
  assign cmp_buf = buf_q;
  assign flag    = flag_q;

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, limit;

  always_comb begin
    limit = DIV_W'((32'd1 << psc) - 32'd1);
    tick  = run && (div_q >= limit);
    if (!run || tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  reload_e          reload,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             wrap,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             pulse_q;
  logic             at_top;
  logic             do_reload;

  always_comb begin
    at_top = (cnt_q >= period);
    wrap   = tick && !cnt_wr && at_top;

    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (tick) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end

    case (reload)
      RLD_ZERO_PRD: do_reload = (cnt_q == '0) || (cnt_q == period);
      RLD_NOW:      do_reload = 1'b1;
      default:      do_reload = (cnt_q == '0);
    endcase
    act_d = do_reload ? cmp_buf : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      pulse_q <= wrap;
    end
  end

  assign cnt     = cnt_q;
  assign cmp_act = act_q;
  assign pulse   = pulse_q;

endmodule

// File: rtl/gpt_cmp_out.sv
module gpt_cmp_out
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             cmp_en,
  input  pol_e             pol,
  input  logic             glb_en,
  output logic             pin
);

  logic active;

  always_comb begin
    active = cmp_en && (cnt >= cmp_act) && (cmp_act <= period);
    if (!glb_en) begin
      pin = 1'b0;
    end else begin
      case (pol)
        POL_ACT_LO: pin = !active;
        POL_ACT_HI: pin = active;
        POL_HIGH:   pin = 1'b1;
        default:    pin = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gp_period_timer.sv
module gp_period_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              cmp_out,
  output logic              period_pulse,
  output logic              period_flag
);

  logic             rst_sync_n;
  logic             run, cmp_en, glb_en, flag_clr, cnt_wr, wrap, tick;
  logic [PSC_W-1:0] psc;
  reload_e          reload;
  pol_e             pol;
  logic [CNT_W-1:0] period_q, cmp_buf, cnt_wdata, cnt_q, cmp_act;

  gpt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wrap(wrap),
    .run(run), .cmp_en(cmp_en), .psc(psc), .reload(reload), .pol(pol),
    .glb_en(glb_en), .period(period_q), .cmp_buf(cmp_buf),
    .flag(period_flag), .flag_clr(flag_clr),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata)
  );

  gpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .psc(psc), .tick(tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .period(period_q),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .reload(reload),
    .cmp_buf(cmp_buf), .cnt(cnt_q), .cmp_act(cmp_act),
    .wrap(wrap), .pulse(period_pulse)
  );

  gpt_cmp_out #(.CNT_W(CNT_W)) u_out (
    .cnt(cnt_q), .period(period_q), .cmp_act(cmp_act), .cmp_en(cmp_en),
    .pol(pol), .glb_en(glb_en), .pin(cmp_out)
  );

  // read-back mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CTL_RUN]               = run;
        rd_data[CTL_CMPEN]             = cmp_en;
        rd_data[CTL_PSC_LSB +: PSC_W]  = psc;
        rd_data[CTL_RLD_LSB +: 2]      = reload;
      end
      A_OUTCTL: begin
        rd_data[OC_POL_LSB +: 2] = pol;
        rd_data[OC_GLB]          = glb_en;
      end
      A_PERIOD: rd_data    = period_q;
      A_CMP:    rd_data    = cmp_buf;
      A_CNT:    rd_data    = cnt_q;
      A_STATUS: rd_data[0] = period_flag;
      default:  rd_data    = '0;
    endcase
  end

endmodule

// File: rtl/gp_period_timer_chk.sv
module gp_period_timer_chk
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick,
  input logic             run,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             pulse,
  input logic             flag,
  input logic             flag_clr,
  input logic             glb_en,
  input logic             cmp_out,
  input reload_e          reload,
  input logic [CNT_W-1:0] cmp_act
);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !cnt_wr && cnt >= period) |=> (cnt == '0));

  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !cnt_wr && cnt < period) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse |-> (cnt == '0));

  a_r3_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse |-> flag);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag && !flag_clr) |=> flag);

  a_r5_shadow_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reload == RLD_ZERO && cnt != '0) |=> $stable(cmp_act));

  a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glb_en |-> !cmp_out);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !cnt_wr) |=> $stable(cnt));

endmodule

bind gp_period_timer gp_period_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick(tick), .run(run),
  .cnt_wr(cnt_wr), .cnt(cnt_q), .period(period_q), .pulse(period_pulse),
  .flag(period_flag), .flag_clr(flag_clr), .glb_en(glb_en),
  .cmp_out(cmp_out), .reload(reload), .cmp_act(cmp_act)
);

// File: tb/gp_period_timer_tb.sv
module gp_period_timer_tb;

  localparam logic [2:0] R_CTRL = 3'd0, R_OC = 3'd1, R_PRD = 3'd2,
                         R_CMP = 3'd3, R_CNT = 3'd4, R_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic        cmp_out, period_pulse, period_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gp_period_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_out(cmp_out), .period_pulse(period_pulse), .period_flag(period_flag)
  );

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    rd(R_CTRL, v); chk16("R11 ctrl after reset", v, 16'd0);
    rd(R_CNT, v);  chk16("R11 counter after reset", v, 16'd0);
    rd(R_PRD, v);  chk16("R11 period after reset", v, 16'd0);
    chk1("R11 cmp_out after reset", cmp_out, 1'b0);
    chk1("R11 flag after reset", period_flag, 1'b0);
    chk1("R11 pulse after reset", period_pulse, 1'b0);
  endtask

  task automatic t_count_wrap;
    logic [15:0] v;
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_PRD, 16'd4);
    wr(R_STAT, 16'd1);
    wr(R_CTRL, 16'h0001);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      rd(R_CNT, v);
      chk16("R1 R2 count sequence", v, 16'(i % 5));
      chk1("R3 pulse timing", period_pulse, (i % 5) == 0);
    end
    chk1("R3 flag after wrap", period_flag, 1'b1);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_PRD, 16'd1000);
    wr(R_CTRL, 16'h0005);
    settle(10);
    rd(R_CNT, v); chk16("R2 divide by 2", v, 16'd5);
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_CTRL, 16'h000D);
    settle(23);
    rd(R_CNT, v); chk16("R2 divide by 8 before step", v, 16'd2);
    settle(1);
    rd(R_CNT, v); chk16("R2 divide by 8 at step", v, 16'd3);
  endtask

  task automatic t_flag;
    logic [15:0] v;
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_PRD, 16'd4);
    wr(R_STAT, 16'd1);
    chk1("R4 flag cleared", period_flag, 1'b0);
    wr(R_CTRL, 16'h0001);
    for (int i = 0; i < 20 && !period_flag; i++) @(negedge clk);
    chk1("R3 flag set by wrap", period_flag, 1'b1);
    wr(R_STAT, 16'd0);
    chk1("R4 write 0 keeps flag", period_flag, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rd(R_CNT, v);
      if (v == 16'd1) break;
    end
    wr_en = 1'b1; wr_addr = R_STAT; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0;
    chk1("R4 write 1 clears flag", period_flag, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rd(R_CNT, v);
      if (v == 16'd4) break;
    end
    wr_en = 1'b1; wr_addr = R_STAT; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0;
    chk1("R4 set wins over clear", period_flag, 1'b1);
    chk1("R3 pulse on collision edge", period_pulse, 1'b1);
  endtask

  task automatic t_stop_load;
    logic [15:0] v;
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_PRD, 16'd1000);
    wr(R_CTRL, 16'h0001);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rd(R_CNT, v);
      if (v == 16'd2) break;
    end
    wr_en = 1'b1; wr_addr = R_CTRL; wr_data = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    settle(5);
    rd(R_CNT, v); chk16("R9 counter held", v, 16'd3);
    wr(R_CNT, 16'd77);
    rd(R_CNT, v); chk16("R9 counter load", v, 16'd77);
    wr(R_CNT, 16'd0);
    rd(R_CNT, v); chk16("R9 counter cleared", v, 16'd0);
  endtask

  task automatic t_shadow;
    logic [15:0] v;
    wr(R_CTRL, 16'h0002);
    wr(R_OC, 16'h0006);
    wr(R_PRD, 16'd10);
    wr(R_CNT, 16'd0);
    wr(R_CMP, 16'd0);
    settle(2);
    wr(R_CNT, 16'd5);
    chk1("R5 initial compare 0 active", cmp_out, 1'b1);
    wr(R_CMP, 16'd7);
    settle(3);
    chk1("R5 buffer held away from zero", cmp_out, 1'b1);
    rd(R_CMP, v); chk16("R5 buffer readback", v, 16'd7);
    wr(R_CNT, 16'd0);
    settle(2);
    wr(R_CNT, 16'd5);
    chk1("R5 loaded at zero", cmp_out, 1'b0);
    wr(R_CTRL, 16'h0042);
    wr(R_CMP, 16'd3);
    settle(2);
    chk1("R5 immediate reload", cmp_out, 1'b1);
    wr(R_CTRL, 16'h0022);
    wr(R_CMP, 16'd9);
    settle(3);
    chk1("R5 zero-or-period mode held", cmp_out, 1'b1);
    wr(R_CNT, 16'd10);
    settle(2);
    wr(R_CNT, 16'd8);
    chk1("R5 loaded at period", cmp_out, 1'b0);
  endtask

  task automatic t_polarity;
    wr(R_CTRL, 16'h0042);
    wr(R_PRD, 16'd10);
    wr(R_CMP, 16'd3);
    wr(R_CNT, 16'd5);
    settle(2);
    wr(R_OC, 16'h0005); chk1("R6 active low while active", cmp_out, 1'b0);
    wr(R_OC, 16'h0006); chk1("R6 active high while active", cmp_out, 1'b1);
    wr(R_CNT, 16'd2);
    chk1("R6 active high while inactive", cmp_out, 1'b0);
    wr(R_OC, 16'h0005); chk1("R6 active low while inactive", cmp_out, 1'b1);
    wr(R_OC, 16'h0004); chk1("R6 forced low", cmp_out, 1'b0);
    wr(R_OC, 16'h0007); chk1("R6 forced high", cmp_out, 1'b1);
    wr(R_OC, 16'h0003); chk1("R7 global off forced high", cmp_out, 1'b0);
    wr(R_OC, 16'h0001); chk1("R7 global off active low", cmp_out, 1'b0);
    wr(R_CNT, 16'd5);
    wr(R_CTRL, 16'h0040);
    wr(R_OC, 16'h0005); chk1("R8 compare off active low", cmp_out, 1'b1);
    wr(R_OC, 16'h0006); chk1("R8 compare off active high", cmp_out, 1'b0);
  endtask

  task automatic t_extremes;
    wr(R_CTRL, 16'h0042);
    wr(R_OC, 16'h0006);
    wr(R_PRD, 16'd10);
    wr(R_CMP, 16'd0);
    wr(R_CNT, 16'd10);
    settle(1);
    chk1("R10 compare 0 at period", cmp_out, 1'b1);
    wr(R_CNT, 16'd0);
    chk1("R10 compare 0 at zero", cmp_out, 1'b1);
    wr(R_CMP, 16'd11);
    wr(R_CNT, 16'd10);
    settle(1);
    chk1("R10 compare above period", cmp_out, 1'b0);
    wr(R_CMP, 16'd10);
    settle(1);
    chk1("R10 compare equal period", cmp_out, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_count_wrap();
    t_prescale();
    t_flag();
    t_stop_load();
    t_shadow();
    t_polarity();
    t_extremes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule